// File: doc/BRIEF.md
# Linked-List Memory Copy Channel

This block is one memory-to-memory copy engine that walks a linked list of descriptors stored in memory. Software writes the address of the first descriptor into the next-descriptor register and then sets the enable bit. The channel reads the descriptor and copies the requested number of bytes, one 32-bit word at a time, from the source address to the destination address. It then follows the descriptor's link word to the next descriptor. A zero link ends the list.

Progress and faults are reported through sticky status flags, which software clears by writing 1 to them. A single interrupt line is raised when a finished descriptor asked for one, or when any fault flag is set. Software can extend a list while the channel runs: it patches the link word of the last descriptor in memory and sets the append bit. The channel then re-reads that link and continues with the new descriptors instead of ending the list.

Register offsets (byte addresses on `regAddr`): 0x00 control, 0x04 status, 0x0C current descriptor (read-only), 0x10 next descriptor, 0x20 remaining byte count (read-only), 0x24 descriptor control (read-only). All other offsets read as zero.

Descriptor layout, one 32-bit word each at ascending word offsets from the descriptor address:

| Word | Content |
|------|---------|
| 0 | link to the next descriptor |
| 1 | source address |
| 2 | upper source address (not read) |
| 3 | destination address |
| 4 | byte count |
| 5 | descriptor control |
| 6 | checksum address (not read) |

Top module: `desc_dma_chan`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and `memReq` is low.
- R2: Writing control bit 0 = 1 while it was 0 starts the channel. The channel copies the descriptor found at the next-descriptor register into the current-descriptor register (0x0C) and reads that descriptor's words 0, 1, 3, 4 and 5. It then copies count/4 words, reading word i from source+4i and writing it to destination+4i, in ascending order.
- R3: After each descriptor, a nonzero link (word 0) is followed to the next descriptor. A zero link ends the list: status bit 8 (end of chain) is set, status bit 10 (busy) reads 0, and register 0x0C keeps the address of the last descriptor.
- R4: Each completed descriptor sets status bit 9 (end of transfer). `irq` rises while bit 9 is set, provided the descriptor that set it had bit 4 (interrupt enable) set in its control word. The control word reads back at 0x24, and the remaining byte count reads back at 0x20.
- R5: Status flags are sticky and are cleared only by writing 1 to their bit position at 0x04. Writing 0 leaves them unchanged. `irq` falls once its flags are cleared.
- R6: End of transfer from a descriptor whose control bit 4 is clear does not raise `irq`.
- R7: A descriptor with a byte count of 0 makes no data access, yet still completes: it sets bit 9 and may raise `irq`.
- R8: A byte count that is not a multiple of 4, or that exceeds MAX_BYTES (16 MiB by default), sets status bit 5. The list then stops with no data access and without bit 9, and `irq` rises.
- R9: Writing control with bit 1 = 1 and bit 0 = 1 requests an append. On an idle channel, the channel re-reads word 0 of the current descriptor and continues from that link if it is nonzero. If the request arrives while the channel is busy, it is held, and at a zero link the channel re-reads that link instead of ending the list.
- R10: Writing control bit 0 = 0 during a copy stops the channel once the current word has been written. Busy clears, 0x0C still holds the interrupted descriptor, 0x20 holds the bytes not yet copied, no flag is set, and no further access follows.
- R11: A memory error reported with the acknowledge sets status bit 1 if it occurs on a descriptor read, bit 2 on a source read, or bit 3 on a destination write. The list then stops and `irq` rises.
- R12: Starting while the next-descriptor register is 0 sets end of chain at once, with no memory access.
- R13: `memReq`, `memWe` and `memAddr` hold steady from the first request cycle until `memAck`, and `memReq` is low whenever the channel is not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Memory byte address, word aligned |
| memWData | output | 32 | Memory write data |
| memRData | input | 32 | Memory read data, valid with memAck |
| memAck | input | 1 | Access completed this cycle |
| memErr | input | 1 | Access failed, valid with memAck |
| irq | output | 1 | Level interrupt |

## Verification
The properties assume that the memory side raises `memAck` only while a request is pending, for a single cycle, and never in the same cycle the request first appears. The bench memory model keeps to this by answering one cycle after it sees a request and dropping the acknowledge on the next edge. The properties also assume that software does not rewrite the next-descriptor register while the channel is busy. The bench changes the list only by patching descriptor words in memory and then issuing an append request.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;
  localparam int WORD_W    = 32;
  localparam int IDX_W     = 3;
  localparam int FETCH_CNT = 5;            // descriptor words actually read
  localparam int DCTL_INTEN = 4;           // interrupt enable in descriptor control

  // descriptor word offsets consumed by the datapath
  localparam logic [IDX_W-1:0] W_NEXT = 3'd0;
  localparam logic [IDX_W-1:0] W_SRC  = 3'd1;
  localparam logic [IDX_W-1:0] W_DST  = 3'd3;
  localparam logic [IDX_W-1:0] W_CNT  = 3'd4;
  localparam logic [IDX_W-1:0] W_DCTL = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FOLLOW, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE, ST_DONE, ST_RESUME
  } dmaState_t;

  typedef enum logic [1:0] {SEL_DESC, SEL_SRC, SEL_DST} addrSel_t;

  typedef struct packed {
    logic             ldCur;      // current descriptor <- next descriptor
    logic             fetchLd;    // load descriptor word wordOff from read data
    logic [IDX_W-1:0] wordOff;    // descriptor word being addressed
    logic             rdLatch;    // capture source word
    logic             advance;    // step addresses, shrink count
    logic             setEot;
    logic             setEoc;
    logic [3:0]       setErr;     // {count, dst write, src read, fetch}
    logic             clrResume;
    addrSel_t         addrSel;
  } dmaStrobe_t;

  // skip the upper-source word: fetch index 0,1,2,3,4 -> word 0,1,3,4,5
  function automatic logic [IDX_W-1:0] fetchWord(input logic [IDX_W-1:0] idx);
    return (idx < 3'd2) ? idx : idx + 3'd1;
  endfunction
endpackage

// File: rtl/desc_dma_ctrl.sv
module desc_dma_ctrl
  import desc_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       startReq,
  input  logic       resumePend,
  input  logic       nextZero,
  input  logic       cntZero,
  input  logic       cntLast,
  input  logic       cntBad,
  input  logic       memAck,
  input  logic       memErr,
  output logic       memReq,
  output logic       memWe,
  output logic       busy,
  output dmaStrobe_t stb
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FETCH_CNT - 1);

  dmaState_t stateQ, stateD;
  logic [IDX_W-1:0] idxQ, idxD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      idxQ   <= '0;
    end else begin
      stateQ <= stateD;
      idxQ   <= idxD;
    end
  end

  always_comb begin
    stateD = stateQ;
    idxD   = idxQ;
    stb    = '0;
    stb.addrSel = SEL_DESC;
    memReq = 1'b0;
    memWe  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startReq) stateD = ST_FOLLOW;
        else if (enable && resumePend) begin
          stb.clrResume = 1'b1;
          stateD = ST_RESUME;
        end
      end
      ST_FOLLOW: begin
        if (nextZero) begin
          stb.setEoc = 1'b1;
          stateD = ST_IDLE;
        end else if (!enable) stateD = ST_IDLE;
        else begin
          stb.ldCur = 1'b1;
          stb.clrResume = 1'b1;
          idxD = '0;
          stateD = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        stb.wordOff = fetchWord(idxQ);
        if (memAck) begin
          if (memErr) begin
            stb.setErr[0] = 1'b1;
            stateD = ST_IDLE;
          end else begin
            stb.fetchLd = 1'b1;
            idxD = idxQ + 1'b1;
            if (idxQ == IDX_LAST) stateD = ST_CHECK;
          end
        end
      end
      ST_CHECK: begin
        if (cntBad) begin
          stb.setErr[3] = 1'b1;
          stateD = ST_IDLE;
        end else if (cntZero) stateD = ST_DONE;
        else stateD = ST_READ;
      end
      ST_READ: begin
        memReq = 1'b1;
        stb.addrSel = SEL_SRC;
        if (memAck) begin
          if (memErr) begin
            stb.setErr[1] = 1'b1;
            stateD = ST_IDLE;
          end else begin
            stb.rdLatch = 1'b1;
            stateD = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        stb.addrSel = SEL_DST;
        if (memAck) begin
          if (memErr) begin
            stb.setErr[2] = 1'b1;
            stateD = ST_IDLE;
          end else begin
            stb.advance = 1'b1;
            if (cntLast) stateD = ST_DONE;
            else if (!enable) stateD = ST_IDLE;
            else stateD = ST_READ;
          end
        end
      end
      ST_DONE: begin
        stb.setEot = 1'b1;
        if (nextZero && resumePend) begin
          stb.clrResume = 1'b1;
          stateD = ST_RESUME;
        end else stateD = ST_FOLLOW;
      end
      ST_RESUME: begin
        memReq = 1'b1;
        stb.wordOff = W_NEXT;
        if (memAck) begin
          if (memErr) begin
            stb.setErr[0] = 1'b1;
            stateD = ST_IDLE;
          end else begin
            stb.fetchLd = 1'b1;
            stateD = ST_FOLLOW;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy = (stateQ != ST_IDLE);
endmodule

// File: rtl/desc_dma_dpath.sv
module desc_dma_dpath
  import desc_dma_pkg::*;
#(
  parameter int REG_AW    = 6,
  parameter int MAX_BYTES = 16777216
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [WORD_W-1:0] regWrData,
  output logic [WORD_W-1:0] regRdData,
  input  dmaStrobe_t        stb,
  input  logic              busy,
  input  logic [WORD_W-1:0] memRData,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWData,
  output logic              irq,
  output logic              enable,
  output logic              startReq,
  output logic              resumePend,
  output logic              nextZero,
  output logic              cntZero,
  output logic              cntLast,
  output logic              cntBad,
  output logic [WORD_W-1:0] statusVec
);
  localparam logic [REG_AW-1:0] OFF_CTRL = REG_AW'(8'h00);
  localparam logic [REG_AW-1:0] OFF_STAT = REG_AW'(8'h04);
  localparam logic [REG_AW-1:0] OFF_CUR  = REG_AW'(8'h0C);
  localparam logic [REG_AW-1:0] OFF_NEXT = REG_AW'(8'h10);
  localparam logic [REG_AW-1:0] OFF_CNT  = REG_AW'(8'h20);
  localparam logic [REG_AW-1:0] OFF_DCTL = REG_AW'(8'h24);
  localparam logic [WORD_W-1:0] MAX_CNT  = WORD_W'(MAX_BYTES);

  logic [WORD_W-1:0] curQ, nextQ, srcQ, dstQ, cntQ, dctlQ, dataQ;
  logic enableQ, resumeQ, eotQ, eocQ, eotIrqQ;
  logic [3:0] errQ, errClr;
  logic ctrlWr, stsWr, clrEot, clrEoc;

  assign ctrlWr = regWrEn && (regAddr == OFF_CTRL);
  assign stsWr  = regWrEn && (regAddr == OFF_STAT);
  assign clrEot = stsWr && regWrData[9];
  assign clrEoc = stsWr && regWrData[8];
  assign errClr = {4{stsWr}} & {regWrData[5], regWrData[3], regWrData[2], regWrData[1]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0; resumeQ <= 1'b0;
      curQ <= '0; nextQ <= '0; srcQ <= '0; dstQ <= '0;
      cntQ <= '0; dctlQ <= '0; dataQ <= '0;
      eotQ <= 1'b0; eocQ <= 1'b0; eotIrqQ <= 1'b0; errQ <= '0;
    end else begin
      if (ctrlWr) enableQ <= regWrData[0];
      if (ctrlWr && regWrData[0] && regWrData[1]) resumeQ <= 1'b1;
      else if (stb.clrResume || (ctrlWr && !regWrData[0])) resumeQ <= 1'b0;
      if (stb.ldCur) curQ <= nextQ;
      if (stb.fetchLd) begin
        unique case (stb.wordOff)
          W_NEXT:  nextQ <= memRData;
          W_SRC:   srcQ  <= memRData;
          W_DST:   dstQ  <= memRData;
          W_CNT:   cntQ  <= memRData;
          W_DCTL:  dctlQ <= memRData;
          default: ;
        endcase
      end else if (regWrEn && (regAddr == OFF_NEXT)) nextQ <= regWrData;
      if (stb.rdLatch) dataQ <= memRData;
      if (stb.advance) begin
        srcQ <= srcQ + WORD_W'(4);
        dstQ <= dstQ + WORD_W'(4);
        cntQ <= cntQ - WORD_W'(4);
      end
      eotQ    <= (eotQ & ~clrEot) | stb.setEot;
      eotIrqQ <= (eotIrqQ & ~clrEot) | (stb.setEot & dctlQ[DCTL_INTEN]);
      eocQ    <= (eocQ & ~clrEoc) | stb.setEoc;
      errQ    <= (errQ & ~errClr) | stb.setErr;
    end
  end

  always_comb begin
    statusVec     = '0;
    statusVec[10] = busy;
    statusVec[9]  = eotQ;
    statusVec[8]  = eocQ;
    statusVec[5]  = errQ[3];
    statusVec[3]  = errQ[2];
    statusVec[2]  = errQ[1];
    statusVec[1]  = errQ[0];
  end

  always_comb begin
    unique case (regAddr)
      OFF_CTRL: regRdData = {{(WORD_W-1){1'b0}}, enableQ};
      OFF_STAT: regRdData = statusVec;
      OFF_CUR:  regRdData = curQ;
      OFF_NEXT: regRdData = nextQ;
      OFF_CNT:  regRdData = cntQ;
      OFF_DCTL: regRdData = dctlQ;
      default:  regRdData = '0;
    endcase
  end

  always_comb begin
    unique case (stb.addrSel)
      SEL_SRC: memAddr = srcQ;
      SEL_DST: memAddr = dstQ;
      default: memAddr = curQ + (WORD_W'(stb.wordOff) << 2);
    endcase
  end

  assign memWData   = dataQ;
  assign irq        = eotIrqQ | (|errQ);
  assign enable     = enableQ;
  assign startReq   = ctrlWr && regWrData[0] && !enableQ;
  assign resumePend = resumeQ;
  assign nextZero   = (nextQ == '0);
  assign cntZero    = (cntQ == '0);
  assign cntLast    = (cntQ == WORD_W'(4));
  assign cntBad     = (cntQ[1:0] != 2'b00) || (cntQ > MAX_CNT);
endmodule

// File: rtl/desc_dma_chan.sv
module desc_dma_chan
  import desc_dma_pkg::*;
#(
  parameter int REG_AW    = 6,
  parameter int MAX_BYTES = 16777216
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memReq,
  output logic              memWe,
  output logic [31:0]       memAddr,
  output logic [31:0]       memWData,
  input  logic [31:0]       memRData,
  input  logic              memAck,
  input  logic              memErr,
  output logic              irq
);
  dmaStrobe_t stbW;
  logic busyW, enableW, startW, resumeW, nextZeroW, cntZeroW, cntLastW, cntBadW;
  logic [31:0] statusW;

  desc_dma_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enableW), .startReq(startW),
    .resumePend(resumeW), .nextZero(nextZeroW), .cntZero(cntZeroW),
    .cntLast(cntLastW), .cntBad(cntBadW), .memAck(memAck), .memErr(memErr),
    .memReq(memReq), .memWe(memWe), .busy(busyW), .stb(stbW)
  );

  desc_dma_dpath #(.REG_AW(REG_AW), .MAX_BYTES(MAX_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .stb(stbW), .busy(busyW),
    .memRData(memRData), .memAddr(memAddr), .memWData(memWData), .irq(irq),
    .enable(enableW), .startReq(startW), .resumePend(resumeW),
    .nextZero(nextZeroW), .cntZero(cntZeroW), .cntLast(cntLastW),
    .cntBad(cntBadW), .statusVec(statusW)
  );
endmodule

// File: rtl/desc_dma_chk.sv
module desc_dma_chk #(
  parameter int REG_AW = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [REG_AW-1:0] regAddr,
  input logic [31:0]       regWrData,
  input logic              memReq,
  input logic              memWe,
  input logic [31:0]       memAddr,
  input logic              memAck,
  input logic              busy,
  input logic [31:0]       statusVec
);
  logic eotClrW;
  assign eotClrW = regWrEn && (regAddr == REG_AW'(8'h04)) && regWrData[9];

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr)));

  p_idle_quiet_r13: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  p_eot_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec[9] && !eotClrW) |=> statusVec[9]);

  p_eoc_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[8]) |-> !busy);

  p_cnt_err_stop_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[5]) |-> !busy);

  p_fetch_err_stop_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusVec[1]) |-> !busy);
endmodule

bind desc_dma_chan desc_dma_chk #(.REG_AW(REG_AW)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memAck(memAck), .busy(busyW), .statusVec(statusW)
);

// File: tb/desc_dma_chan_tb_top.sv
`timescale 1ns/1ps
module desc_dma_chan_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [5:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic memReq, memWe;
  logic [31:0] memAddr, memWData;
  logic [31:0] memRData = '0;
  logic memAck = 1'b0;
  logic memErr = 1'b0;
  logic irq;

  always #2.5 clk = ~clk;

  desc_dma_chan dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .memAck(memAck), .memErr(memErr), .irq(irq)
  );

  logic [31:0] mem [0:4095];
  logic [63:0] expQ [$];
  int chkCnt = 0;
  int errCnt = 0;
  int wrSeen = 0;
  int reqSeen = 0;
  bit freeRun = 1'b0;
  logic [31:0] errAddr = 32'hFFFF_FFFF;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory model + write monitor (scoreboard pop side)
  always @(posedge clk) begin
    if (memAck) begin
      memAck <= 1'b0;
      memErr <= 1'b0;
    end else if (memReq) begin
      reqSeen++;
      memAck <= 1'b1;
      memErr <= (memAddr == errAddr);
      if (memWe) begin
        mem[memAddr[13:2]] = memWData;
        wrSeen++;
        if (!freeRun) begin
          if (expQ.size() == 0) check(1'b0, "R2 unexpected write", memAddr, 32'h0);
          else begin
            logic [63:0] e;
            e = expQ.pop_front();
            check(e[63:32] == memAddr, "R2 write address", memAddr, e[63:32]);
            check(e[31:0] == memWData, "R2 write data", memWData, e[31:0]);
          end
        end
      end else memRData <= mem[memAddr[13:2]];
    end
  end

  task automatic regWr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic putDesc(input logic [31:0] b, input logic [31:0] nxt, input logic [31:0] src,
                         input logic [31:0] dst, input logic [31:0] cnt, input logic [31:0] ctl);
    mem[b[13:2]]     = nxt;
    mem[b[13:2] + 1] = src;
    mem[b[13:2] + 2] = 32'hDEAD_0002;
    mem[b[13:2] + 3] = dst;
    mem[b[13:2] + 4] = cnt;
    mem[b[13:2] + 5] = ctl;
    mem[b[13:2] + 6] = 32'hDEAD_0006;
  endtask

  // scoreboard push side
  task automatic pushCopy(input logic [31:0] src, input logic [31:0] dst, input int cnt);
    for (int i = 0; i < cnt / 4; i++)
      expQ.push_back({dst + 32'(4 * i), mem[src[13:2] + 12'(i)]});
  endtask

  task automatic startAt(input logic [31:0] b);
    regWr(6'h00, 32'h0);
    regWr(6'h10, b);
    regWr(6'h00, 32'h1);
  endtask

  task automatic waitIdle();
    logic [31:0] s;
    int n;
    n = 0;
    repeat (2) @(negedge clk);
    regRd(6'h04, s);
    while (s[10] && n < 20000) begin
      regRd(6'h04, s);
      n++;
    end
  endtask

  task automatic clearAll();
    regWr(6'h04, 32'h0000_03FF);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, errCnt);
    $finish;
  end

  initial begin : stim
    logic [31:0] v, rem;
    int w0, r0;
    for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
    for (int i = 1024; i < 2048; i++) mem[i] = 32'(i) * 32'h9E37_79B1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    regRd(6'h00, v); check(v == 0, "R1 control", v, 0);
    regRd(6'h04, v); check(v == 0, "R1 status", v, 0);
    regRd(6'h0C, v); check(v == 0, "R1 current", v, 0);
    regRd(6'h10, v); check(v == 0, "R1 next", v, 0);
    check(irq == 0, "R1 irq", 32'(irq), 0);
    check(memReq == 0, "R1 memReq", 32'(memReq), 0);

    // R2 R3 R4 single descriptor with interrupt
    putDesc(32'h100, 0, 32'h1000, 32'h2000, 16, 32'h5E);
    pushCopy(32'h1000, 32'h2000, 16);
    startAt(32'h100); waitIdle();
    check(expQ.size() == 0, "R2 all words copied", 32'(expQ.size()), 0);
    regRd(6'h04, v); check(v == 32'h300, "R3 status after end", v, 32'h300);
    regRd(6'h0C, v); check(v == 32'h100, "R3 current descriptor", v, 32'h100);
    regRd(6'h20, v); check(v == 0, "R4 count readback", v, 0);
    regRd(6'h24, v); check(v == 32'h5E, "R4 control readback", v, 32'h5E);
    check(irq == 1, "R4 irq on end of transfer", 32'(irq), 1);

    // R5 write-1-to-clear
    regWr(6'h04, 32'h200);
    regRd(6'h04, v); check(v == 32'h100, "R5 clear bit9 only", v, 32'h100);
    check(irq == 0, "R5 irq falls", 32'(irq), 0);
    regWr(6'h04, 32'h0);
    regRd(6'h04, v); check(v == 32'h100, "R5 zero write keeps", v, 32'h100);
    regWr(6'h04, 32'h100);
    regRd(6'h04, v); check(v == 0, "R5 clear bit8", v, 0);

    // R3 R6 two-descriptor chain, no interrupt enable
    putDesc(32'h140, 32'h180, 32'h1100, 32'h2100, 8, 32'h4E);
    putDesc(32'h180, 0, 32'h1200, 32'h2200, 12, 32'h4E);
    pushCopy(32'h1100, 32'h2100, 8);
    pushCopy(32'h1200, 32'h2200, 12);
    startAt(32'h140); waitIdle();
    check(expQ.size() == 0, "R3 chain copied", 32'(expQ.size()), 0);
    regRd(6'h0C, v); check(v == 32'h180, "R3 last descriptor", v, 32'h180);
    regRd(6'h04, v); check(v == 32'h300, "R3 chain status", v, 32'h300);
    check(irq == 0, "R6 no irq without enable", 32'(irq), 0);
    clearAll();

    // R9 append on idle channel
    putDesc(32'h1C0, 0, 32'h1300, 32'h2300, 8, 32'h5E);
    mem[32'h180 >> 2] = 32'h1C0;
    pushCopy(32'h1300, 32'h2300, 8);
    regWr(6'h00, 32'h3); waitIdle();
    check(expQ.size() == 0, "R9 appended copy", 32'(expQ.size()), 0);
    regRd(6'h0C, v); check(v == 32'h1C0, "R9 current after append", v, 32'h1C0);
    regRd(6'h04, v); check(v == 32'h300, "R9 status", v, 32'h300);
    clearAll();

    // R7 zero count
    putDesc(32'h200, 0, 32'h1000, 32'h2000, 0, 32'h5E);
    w0 = wrSeen;
    startAt(32'h200); waitIdle();
    check(wrSeen == w0, "R7 no data writes", 32'(wrSeen - w0), 0);
    regRd(6'h04, v); check(v == 32'h300, "R7 completes", v, 32'h300);
    check(irq == 1, "R7 irq", 32'(irq), 1);
    clearAll();

    // R8 bad counts
    putDesc(32'h240, 0, 32'h1000, 32'h2000, 6, 32'h5E);
    w0 = wrSeen;
    startAt(32'h240); waitIdle();
    regRd(6'h04, v); check(v == 32'h20, "R8 unaligned count", v, 32'h20);
    check(irq == 1, "R8 irq", 32'(irq), 1);
    check(wrSeen == w0, "R8 no writes", 32'(wrSeen - w0), 0);
    clearAll();
    check(irq == 0, "R8 irq cleared", 32'(irq), 0);
    putDesc(32'h280, 0, 32'h1000, 32'h2000, 32'h0100_0004, 32'h5E);
    startAt(32'h280); waitIdle();
    regRd(6'h04, v); check(v == 32'h20, "R8 oversize count", v, 32'h20);
    clearAll();

    // R11 memory errors
    putDesc(32'h2C0, 0, 32'h1400, 32'h2400, 8, 32'h4E);
    errAddr = 32'h1400;
    startAt(32'h2C0); waitIdle();
    regRd(6'h04, v); check(v == 32'h04, "R11 source read error", v, 32'h04);
    check(irq == 1, "R11 irq", 32'(irq), 1);
    clearAll();
    putDesc(32'h300, 0, 32'h1400, 32'h2400, 8, 32'h4E);
    errAddr = 32'h30C;
    startAt(32'h300); waitIdle();
    regRd(6'h04, v); check(v == 32'h02, "R11 fetch error", v, 32'h02);
    clearAll();
    putDesc(32'h340, 0, 32'h1500, 32'h2500, 8, 32'h4E);
    expQ.push_back({32'h2500, mem[32'h1500 >> 2]});
    errAddr = 32'h2500;
    startAt(32'h340); waitIdle();
    regRd(6'h04, v); check(v == 32'h08, "R11 write error", v, 32'h08);
    check(expQ.size() == 0, "R11 one write issued", 32'(expQ.size()), 0);
    errAddr = 32'hFFFF_FFFF;
    clearAll();

    // R12 start with empty list
    r0 = reqSeen;
    startAt(32'h0); waitIdle();
    regRd(6'h04, v); check(v == 32'h100, "R12 end of chain", v, 32'h100);
    check(reqSeen == r0, "R12 no access", 32'(reqSeen - r0), 0);
    clearAll();

    // R9 append while busy
    putDesc(32'h380, 0, 32'h1600, 32'h2600, 256, 32'h4E);
    putDesc(32'h3C0, 0, 32'h1800, 32'h2800, 8, 32'h5E);
    pushCopy(32'h1600, 32'h2600, 256);
    pushCopy(32'h1800, 32'h2800, 8);
    startAt(32'h380);
    repeat (20) @(negedge clk);
    mem[32'h380 >> 2] = 32'h3C0;
    regWr(6'h00, 32'h3); waitIdle();
    check(expQ.size() == 0, "R9 busy append copied", 32'(expQ.size()), 0);
    regRd(6'h0C, v); check(v == 32'h3C0, "R9 busy append current", v, 32'h3C0);
    regRd(6'h04, v); check(v == 32'h300, "R9 busy append status", v, 32'h300);
    clearAll();

    // R10 disable mid transfer
    putDesc(32'h400, 32'h140, 32'h1000, 32'h3000, 256, 32'h5E);
    freeRun = 1'b1;
    regWr(6'h00, 32'h0);
    wrSeen = 0;
    regWr(6'h10, 32'h400);
    regWr(6'h00, 32'h1);
    while (wrSeen < 5) @(negedge clk);
    regWr(6'h00, 32'h0); waitIdle();
    w0 = wrSeen;
    regRd(6'h20, rem);
    check(rem != 0 && rem + 32'(4 * wrSeen) == 256, "R10 remaining count", rem, 32'(256 - 4 * wrSeen));
    regRd(6'h0C, v); check(v == 32'h400, "R10 current kept", v, 32'h400);
    regRd(6'h04, v); check(v == 0, "R10 no flags", v, 0);
    repeat (20) @(negedge clk);
    check(wrSeen == w0, "R10 no access after stop", 32'(wrSeen), 32'(w0));
    check(irq == 0, "R10 irq low", 32'(irq), 0);
    freeRun = 1'b0;

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", chkCnt, errCnt);
    $finish;
  end
endmodule